// File: doc/BRIEF.md
# Fault-Aware Frontend Instruction Router

This block sits between instruction fetch and decode. Each cycle it takes a fetch group of up to N instruction slots, each with its own valid bit, and steers the live instructions onto the frontend ways that the fault mask marks as healthy. Program order is kept. Older slots go to lower-numbered healthy ways. If a group holds more live instructions than there are healthy ways, the block raises a stall to fetch and sends the rest in the following cycles.

Fetch keeps its group on the inputs for as long as the stall is high. The router remembers only which slots are still waiting. Each way has its own output multiplexer. The select logic for each multiplexer works out that way's rank among the healthy ways from the fault mask alone, so no way's control depends on another way's control. The per-way outputs are registered. When downstream is not ready, the outputs and the waiting-slot state both hold.

Top module: `fr_router`

## Requirements
- R1: After reset, every `way_vld` bit is 0 and no slots are waiting. With `dn_ready` high, at least one healthy way, and no group presented, `fetch_stall` is low.
- R2: Slot 0 is the oldest slot and way 0 is the lowest way. Within one cycle, the k-th oldest waiting valid slot (k counted from 0) goes to the k-th lowest way whose `fault_map` bit is 0.
- R3: A way whose `fault_map` bit is 1 never has its `way_vld` bit asserted.
- R4: If the waiting valid slots outnumber the healthy ways, `fetch_stall` is high in that cycle. The leftover slots are steered in later cycles, oldest first, by the same rule as R2.
- R5: `fetch_stall` is low in the cycle in which the last waiting slots of a group are steered. The group is consumed at that clock edge.
- R6: Slots whose valid bit is 0 are skipped and use up no way.
- R7: If every `fault_map` bit is 1, no `way_vld` bit is asserted and `fetch_stall` stays high.
- R8: A slot steered at a clock edge appears on `way_vld`/`way_insn` just after that same edge, so there is one register stage.
- R9: While `dn_ready` is low, `fetch_stall` is high, and the outputs and the waiting-slot state do not change.
- R10: With `grp_valid` low and no slots waiting, the next registered outputs are all invalid and `fetch_stall` is low, provided `dn_ready` is high and at least one way is healthy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A fetch group is on the slot inputs |
| slot_vld | input | N | Per-slot valid bits; bit 0 is the oldest slot |
| slot_insn | input | N*IW | Slot instructions; slot i is at bits [i*IW +: IW] |
| fault_map | input | N | Per-way fault bits; 1 means the way is faulty |
| dn_ready | input | 1 | Decode can take the outputs this cycle |
| way_vld | output | N | Registered per-way valid bits |
| way_insn | output | N*IW | Registered per-way instructions; way w is at bits [w*IW +: IW] |
| fetch_stall | output | 1 | Tells fetch to hold its current group |

## Verification
`fetch_stall` is combinational. It is checked one time unit after the inputs change, in the same cycle, before the clock edge that would consume the group. The steered instructions are checked one register stage later: the driver queues the expected way vector at the falling edge before each rising edge, and the monitor pops and compares it shortly after that rising edge. During backpressure cycles the queued item is the previous output again, so the hold behaviour is checked on the same timeline.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int FR_MAXW = 32;

    typedef logic [7:0] cnt_t;

    typedef struct packed {
        logic       hit;
        logic [4:0] idx;
    } pick_t;

    function automatic cnt_t pop32(logic [FR_MAXW-1:0] v);
        cnt_t n;
        n = '0;
        for (int i = 0; i < FR_MAXW; i++) begin
            if (v[i]) n = n + cnt_t'(1);
        end
        return n;
    endfunction

    // position of the n-th set bit (n counted from 0)
    function automatic pick_t nth_set(logic [FR_MAXW-1:0] v, cnt_t n);
        pick_t r;
        cnt_t  seen;
        r    = '0;
        seen = '0;
        for (int i = 0; i < FR_MAXW; i++) begin
            if (v[i]) begin
                if (seen == n && !r.hit) begin
                    r.hit = 1'b1;
                    r.idx = 5'(i);
                end
                seen = seen + cnt_t'(1);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fr_way_sel.sv
module fr_way_sel
    import fr_pkg::*;
#(
    parameter int N   = 4,
    parameter int IW  = 32,
    parameter int WAY = 0
) (
    input  logic [N-1:0]    src_mask,
    input  logic [N-1:0]    fault_mask,
    input  logic [N*IW-1:0] insn_flat,
    output logic            sel_vld,
    output logic [IW-1:0]   sel_insn
);
    localparam int PAD = FR_MAXW - N;

    cnt_t  rank;
    pick_t pick;

    // private rank: healthy ways strictly below this one
    always_comb begin
        rank = '0;
        for (int i = 0; i < WAY; i++) begin
            if (!fault_mask[i]) rank = rank + cnt_t'(1);
        end
    end

    assign pick    = nth_set({{PAD{1'b0}}, src_mask}, rank);
    assign sel_vld = !fault_mask[WAY] && pick.hit;

    always_comb begin
        sel_insn = '0;
        for (int i = 0; i < N; i++) begin
            if (5'(i) == pick.idx) sel_insn = insn_flat[i*IW +: IW];
        end
    end

endmodule

// File: rtl/fr_pend.sv
module fr_pend
    import fr_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_mask,
    input  cnt_t         good_cnt,
    input  cnt_t         src_cnt,
    input  logic         adv,
    output logic         pend_act,
    output logic [N-1:0] pend_mask
);
    logic [N-1:0] nxt_mask;
    cnt_t         taken;

    // clear the oldest good_cnt live slots
    always_comb begin
        nxt_mask = src_mask;
        taken    = '0;
        for (int i = 0; i < N; i++) begin
            if (src_mask[i] && taken < good_cnt) begin
                nxt_mask[i] = 1'b0;
                taken       = taken + cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_act  <= 1'b0;
            pend_mask <= '0;
        end else if (adv && good_cnt != '0) begin
            pend_act  <= (src_cnt > good_cnt);
            pend_mask <= (src_cnt > good_cnt) ? nxt_mask : '0;
        end
    end

    // R4
    pend_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        pend_act && $past(pend_act) |-> (pend_mask & ~$past(pend_mask)) == '0);

endmodule

// File: rtl/fr_router.sv
module fr_router
    import fr_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            grp_valid,
    input  logic [N-1:0]    slot_vld,
    input  logic [N*IW-1:0] slot_insn,
    input  logic [N-1:0]    fault_map,
    input  logic            dn_ready,
    output logic [N-1:0]    way_vld,
    output logic [N*IW-1:0] way_insn,
    output logic            fetch_stall
);
    localparam int PAD = FR_MAXW - N;

    logic         pend_act;
    logic [N-1:0] pend_mask;
    logic [N-1:0] src_mask;
    cnt_t         good_cnt;
    cnt_t         src_cnt;
    logic [N-1:0]    nx_vld;
    logic [N*IW-1:0] nx_insn;

    assign src_mask = pend_act ? pend_mask : (grp_valid ? slot_vld : '0);
    assign good_cnt = pop32({{PAD{1'b0}}, ~fault_map});
    assign src_cnt  = pop32({{PAD{1'b0}}, src_mask});

    assign fetch_stall = !dn_ready || (good_cnt == '0) || (src_cnt > good_cnt);

    fr_pend #(.N(N)) pend_i (
        .clk       (clk),
        .rst       (rst),
        .src_mask  (src_mask),
        .good_cnt  (good_cnt),
        .src_cnt   (src_cnt),
        .adv       (dn_ready),
        .pend_act  (pend_act),
        .pend_mask (pend_mask)
    );

    for (genvar w = 0; w < N; w++) begin : g_way
        fr_way_sel #(.N(N), .IW(IW), .WAY(w)) sel_i (
            .src_mask   (src_mask),
            .fault_mask (fault_map),
            .insn_flat  (slot_insn),
            .sel_vld    (nx_vld[w]),
            .sel_insn   (nx_insn[w*IW +: IW])
        );

        // R3
        faulty_way_idle_chk: assert property (@(posedge clk) disable iff (rst)
            way_vld[w] && $past(dn_ready) |-> !$past(fault_map[w]));

        if (w > 0) begin : g_pack
            // R2
            lower_ways_filled_chk: assert property (@(posedge clk) disable iff (rst)
                way_vld[w] && $past(dn_ready) |->
                    &(way_vld[w-1:0] | $past(fault_map[w-1:0])));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            way_vld  <= '0;
            way_insn <= '0;
        end else if (dn_ready) begin
            way_vld  <= nx_vld;
            way_insn <= nx_insn;
        end
    end

    // R7
    all_faulty_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (&fault_map) && dn_ready |=> way_vld == '0);

    // R5
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_stall |=> !pend_act);

    // R9
    backpressure_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dn_ready |=> $stable(way_vld) && $stable(pend_mask));

endmodule

// File: tb/fr_router_tb_top.sv
module fr_router_tb_top;
    localparam int N  = 4;
    localparam int IW = 32;

    typedef struct {
        logic [N-1:0]    vld;
        logic [N*IW-1:0] insn;
    } beat_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            grp_valid = 1'b0;
    logic [N-1:0]    slot_vld = '0;
    logic [N*IW-1:0] slot_insn = '0;
    logic [N-1:0]    fault_map = '0;
    logic            dn_ready = 1'b1;
    logic [N-1:0]    way_vld;
    logic [N*IW-1:0] way_insn;
    logic            fetch_stall;

    int n_cmp = 0;
    int n_bad = 0;
    beat_t exp_q[$];

    logic [N-1:0]    m_rem = '0;
    bit              m_act = 1'b0;
    logic [N-1:0]    e_vld = '0;
    logic [N*IW-1:0] e_insn = '0;
    bit              last_stall;

    always #5 clk = ~clk;

    fr_router #(.N(N), .IW(IW)) dut_i (
        .clk(clk), .rst(rst), .grp_valid(grp_valid), .slot_vld(slot_vld),
        .slot_insn(slot_insn), .fault_map(fault_map), .dn_ready(dn_ready),
        .way_vld(way_vld), .way_insn(way_insn), .fetch_stall(fetch_stall)
    );

    task automatic check(string req, bit ok, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] insn_of(int gid, int s);
        return IW'(32'hA000_0000 + gid * 16 + s);
    endfunction

    // one cycle: drive at falling edge, check stall, queue expected output
    task automatic step(string req, bit rdy, bit gv, logic [N-1:0] sm,
                        logic [N-1:0] fm, int gid);
        logic [N-1:0] src;
        int g, c, s;
        bit stall_e;
        beat_t b;
        @(negedge clk);
        dn_ready  = rdy;
        grp_valid = gv;
        slot_vld  = sm;
        fault_map = fm;
        for (int i = 0; i < N; i++) slot_insn[i*IW +: IW] = insn_of(gid, i);
        #1;
        src = m_act ? m_rem : (gv ? sm : '0);
        g = 0; c = 0;
        for (int i = 0; i < N; i++) begin
            if (!fm[i]) g++;
            if (src[i]) c++;
        end
        stall_e = !rdy || g == 0 || c > g;
        check({req, " stall"}, fetch_stall == stall_e, 128'(fetch_stall), 128'(stall_e));
        last_stall = stall_e;
        if (rdy) begin
            e_vld = '0;
            s = 0;
            for (int w = 0; w < N; w++) begin
                if (!fm[w]) begin
                    while (s < N && !src[s]) s++;
                    if (s < N) begin
                        e_vld[w] = 1'b1;
                        e_insn[w*IW +: IW] = insn_of(gid, s);
                        src[s] = 1'b0;
                        s++;
                    end
                end
            end
            if (g > 0) begin
                m_act = (c > g);
                m_rem = m_act ? src : '0;
            end
        end
        b.vld  = e_vld;
        b.insn = e_insn;
        exp_q.push_back(b);
    endtask

    task automatic send_group(string req, logic [N-1:0] sm, logic [N-1:0] fm, int gid);
        int k = 0;
        do begin
            step(req, 1'b1, 1'b1, sm, fm, gid);
            k++;
        end while (last_stall && k < 20);
    endtask

    // monitor: compares the registered outputs shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                beat_t b;
                b = exp_q.pop_front();
                check("R2/R8 way_vld", way_vld == b.vld, 128'(way_vld), 128'(b.vld));
                for (int w = 0; w < N; w++) begin
                    if (b.vld[w])
                        check("R2 way_insn", way_insn[w*IW +: IW] == b.insn[w*IW +: IW],
                              128'(way_insn[w*IW +: IW]), 128'(b.insn[w*IW +: IW]));
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 vld", way_vld == '0, 128'(way_vld), 128'(0));
        check("R1 stall", fetch_stall == 1'b0, 128'(fetch_stall), 128'(0));

        // R10: idle cycle
        step("R10", 1'b1, 1'b0, 4'b1111, 4'b0000, 0);
        // R2 R8: full group, all healthy
        send_group("R2", 4'b1111, 4'b0000, 1);
        // R4 R5 R3: one faulty way, group spills over
        send_group("R4", 4'b1111, 4'b0010, 2);
        // R6: sparse slots
        send_group("R6", 4'b1010, 4'b0000, 3);
        // R6 with fault on way 0
        send_group("R6", 4'b1101, 4'b0001, 4);
        // R4: single healthy way, four cycles
        send_group("R4", 4'b1111, 4'b1101, 5);
        // R9: backpressure in the middle of a spilled group
        step("R9", 1'b1, 1'b1, 4'b1111, 4'b0011, 6);
        step("R9", 1'b0, 1'b1, 4'b1111, 4'b0011, 6);
        step("R9", 1'b0, 1'b1, 4'b1111, 4'b0011, 6);
        send_group("R5", 4'b1111, 4'b0011, 6);
        // R7: all ways faulty
        step("R7", 1'b1, 1'b1, 4'b0111, 4'b1111, 7);
        step("R7", 1'b1, 1'b1, 4'b0111, 4'b1111, 7);
        step("R7", 1'b1, 1'b1, 4'b0111, 4'b1111, 7);
        // recovery once ways are healthy again
        send_group("R3", 4'b0111, 4'b1000, 7);
        // back-to-back groups
        send_group("R2", 4'b0011, 4'b0000, 8);
        send_group("R2", 4'b1100, 4'b0100, 9);
        step("R10", 1'b1, 1'b0, 4'b0000, 4'b0000, 10);
        step("R10", 1'b1, 1'b0, 4'b0000, 4'b0000, 10);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule